// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This core collects up to eight interrupt lines into a request register, filters them through a mask register and picks a single winner by rotating priority. The priority order starts at a programmable 3-bit base, so the line equal to the base ranks first. The winner is compared against the most urgent line already in service. The core raises `int_req` only when the new request is strictly more urgent than that line. A processor-side acknowledge takes the winner, and end-of-interrupt commands retire lines. Some of those commands also move the priority base.

A byte-wide register port has three addresses: command, data and trigger select. A short initialization sequence runs through the data address. It sets the vector base and the operating options, which are auto end-of-interrupt and special nested mode for the cascade line. Outside that sequence, the data address holds the mask. A command-address option can switch reads to the in-service register or arm a poll read. A poll read returns and retires the current winner without an acknowledge cycle.

Top module: `pic_core`

## Requirements
- R1: After reset `int_req` is 0 and the request, in-service and mask registers read 0. The priority base is 0 and the trigger-select register reads 0.
- R2: The effective priority of line n is (n - base) mod 8, and 0 is the most urgent. `int_req` is 1 only when an unmasked request exists whose priority is strictly more urgent than every in-service line.
- R3: Outside initialization, a write to data address 1 loads the mask, and a read of address 1 returns it. A line whose mask bit is 1 never causes `int_req`.
- R4: Address 2 is the trigger-select register. Bit n = 1 makes line n level sensed, and the request bit then follows the input. Bit n = 0 makes line n edge sensed: a 0-to-1 input change sets the request bit, and the bit stays set after the input falls. Bits outside `TRIG_MASK` (default 8'hF8) always read 0.
- R5: A one-cycle `ack` clears the winner's request bit and sets its in-service bit. `ack_vector` shows the vector base OR the winning line. With no winner it shows the vector base OR 7.
- R6: A command-address write with bit 4 = 1 starts initialization. It clears every register, including the priority base, and holds `int_req` at 0 until the sequence completes. In that write, bit 0 = 1 announces a mode word and bit 1 = 1 skips the cascade word.
- R7: The first data write after the start word sets the vector base to the byte with its low 3 bits forced to 0.
- R8: In the mode word, bit 1 enables auto end-of-interrupt, so an acknowledge sets no in-service bit. Bit 4 enables special nested mode.
- R9: A command write with bits 4:3 = 00 decodes bits 7:5 as an operation, and operations 0, 2 and 4 do nothing. Operation 1 clears the most urgent in-service bit. Operation 3 clears the in-service bit of line bits 2:0. Neither of these moves the base.
- R10: Operation 5 clears the most urgent in-service bit and sets base = (that line + 1) mod 8. Operation 6 sets base = (bits 2:0 + 1) mod 8. Operation 7 clears the in-service bit of line bits 2:0 and sets base = (that line + 1) mod 8.
- R11: A command write with bits 4:3 = 01 is an option write. If bit 1 is 1, bit 0 selects in-service (1) or request (0) reads at address 0. Bit 2 = 1 arms a poll. The next address-0 read then returns the winner's line number and clears both its request and in-service bits, or returns 7 when there is no winner.
- R12: On a master instance in special nested mode, the in-service bit of the cascade line (line 2) is left out of the urgency comparison. A new request on line 2 can then interrupt while line 2 is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | LINES | Interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (poll reads have side effects) |
| bus_addr | input | 2 | 0 command, 1 data/mask, 2 trigger select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| ack | input | 1 | One-cycle interrupt acknowledge |
| ack_vector | output | 8 | Vector of the current winner (vector base OR line) |
| int_req | output | 1 | Interrupt request to the processor |

## Verification
A wrong base or a misplaced in-service bit does not show up at once. It shows on the next acknowledge, when `ack_vector` names a different line than the rotated order predicts, or on the next request, when `int_req` rises or stays low against the nesting rule. The bench therefore sets up each base and in-service state with a command and then probes it within a few cycles. It uses a fresh request pair or an in-service read-back for this. Trigger-mode errors show in the request read-back one cycle after the input changes.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        INIT_IDLE = 2'd0,
        INIT_BASE = 2'd1,
        INIT_CASC = 2'd2,
        INIT_MODE = 2'd3
    } init_e;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_TRIG = 2'd2;

    // operation codes in command bits 7:5 (bits 4:3 = 00)
    localparam logic [2:0] OP_EOI      = 3'd1;
    localparam logic [2:0] OP_SPEC_EOI = 3'd3;
    localparam logic [2:0] OP_ROT_EOI  = 3'd5;
    localparam logic [2:0] OP_SET_PRI  = 3'd6;
    localparam logic [2:0] OP_ROT_SPEC = 3'd7;

endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec,
    input  logic [IDX_W-1:0] base,
    output logic             hit,
    output logic [IDX_W-1:0] line,
    output logic [IDX_W-1:0] rank
);
    logic [IDX_W-1:0] idx;

    // scan from lowest urgency to highest so the most urgent set bit wins
    always_comb begin
        hit  = 1'b0;
        line = '0;
        rank = '0;
        idx  = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            idx = base + IDX_W'(k);
            if (vec[idx]) begin
                hit  = 1'b1;
                line = idx;
                rank = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0] irq,
    input  logic [LINES-1:0] prev,
    input  logic [LINES-1:0] trig,
    input  logic [LINES-1:0] irr,
    output logic [LINES-1:0] irr_nxt
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        // level lines track the pin, edge lines hold once set
        assign irr_nxt[i] = trig[i] ? irq[i] : (irr[i] | (irq[i] & ~prev[i]));
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int              LINES        = 8,
    parameter bit              IS_MASTER    = 1'b1,
    parameter int              CASCADE_LINE = 2,
    parameter logic [LINES-1:0] TRIG_MASK   = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ack,
    output logic [BUS_W-1:0] ack_vector,
    output logic             int_req
);
    localparam int IDX_W = $clog2(LINES);
    localparam logic [BUS_W-1:0] VEC_MASK = ~BUS_W'(LINES - 1);

    typedef struct packed {
        logic [LINES-1:0] irr;
        logic [LINES-1:0] imr;
        logic [LINES-1:0] isr;
        logic [LINES-1:0] trig;
        logic [LINES-1:0] prev;
        logic [IDX_W-1:0] base;
        logic [BUS_W-1:0] vbase;
        init_e            init;
        logic             need4;
        logic             single;
        logic             aeoi;
        logic             sfnm;
        logic             sel_isr;
        logic             poll;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] v);
        return v + IDX_W'(1);
    endfunction

    // ---------------- request latching ----------------
    logic [LINES-1:0] irr_lat;
    pic_req_latch #(.LINES(LINES)) u_latch (
        .irq    (irq_in),
        .prev   (st_q.prev),
        .trig   (st_q.trig),
        .irr    (st_q.irr),
        .irr_nxt(irr_lat)
    );

    // ---------------- priority resolution ----------------
    logic [LINES-1:0] req_vec, isr_cmp;
    logic             req_hit, cmp_hit, top_hit;
    logic [IDX_W-1:0] req_line, req_rank, cmp_line, cmp_rank, top_line, top_rank;

    always_comb begin
        req_vec = st_q.irr & ~st_q.imr;
        isr_cmp = st_q.isr;
        if (IS_MASTER && st_q.sfnm) isr_cmp[CASCADE_LINE] = 1'b0;
    end

    pic_prio_pick #(.LINES(LINES)) u_pick_req (
        .vec(req_vec), .base(st_q.base), .hit(req_hit), .line(req_line), .rank(req_rank)
    );
    pic_prio_pick #(.LINES(LINES)) u_pick_cmp (
        .vec(isr_cmp), .base(st_q.base), .hit(cmp_hit), .line(cmp_line), .rank(cmp_rank)
    );
    pic_prio_pick #(.LINES(LINES)) u_pick_top (
        .vec(st_q.isr), .base(st_q.base), .hit(top_hit), .line(top_line), .rank(top_rank)
    );

    logic unused_pick_bits;
    assign unused_pick_bits = ^{cmp_line, top_rank};

    logic             win_hit;
    logic [IDX_W-1:0] win_line;
    assign win_hit  = req_hit && (!cmp_hit || (req_rank < cmp_rank));
    assign win_line = req_line;

    assign int_req    = win_hit && (st_q.init == INIT_IDLE);
    assign ack_vector = st_q.vbase | (win_hit ? BUS_W'(win_line) : BUS_W'(LINES - 1));

    // ---------------- register port ----------------
    logic             poll_rd;
    logic [IDX_W-1:0] fld_line;
    assign poll_rd  = bus_rd && (bus_addr == ADDR_CMD) && st_q.poll;
    assign fld_line = bus_wdata[IDX_W-1:0];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CMD: begin
                if (st_q.poll)
                    bus_rdata = win_hit ? BUS_W'(win_line) : BUS_W'(LINES - 1);
                else if (st_q.sel_isr)
                    bus_rdata = BUS_W'(st_q.isr);
                else
                    bus_rdata = BUS_W'(st_q.irr);
            end
            ADDR_DATA: bus_rdata = BUS_W'(st_q.imr);
            ADDR_TRIG: bus_rdata = BUS_W'(st_q.trig);
            default:   bus_rdata = '0;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        st_d.irr  = irr_lat;

        if (ack && win_hit) begin
            st_d.irr[win_line] = 1'b0;
            if (!st_q.aeoi) st_d.isr[win_line] = 1'b1;
        end

        if (poll_rd) begin
            st_d.poll = 1'b0;
            if (win_hit) begin
                st_d.irr[win_line] = 1'b0;
                st_d.isr[win_line] = 1'b0;
            end
        end

        if (bus_wr) begin
            case (bus_addr)
                ADDR_CMD: begin
                    if (bus_wdata[4]) begin
                        st_d        = '0;
                        st_d.init   = INIT_BASE;
                        st_d.need4  = bus_wdata[0];
                        st_d.single = bus_wdata[1];
                    end else if (bus_wdata[3]) begin
                        if (bus_wdata[2]) st_d.poll = 1'b1;
                        if (bus_wdata[1]) st_d.sel_isr = bus_wdata[0];
                    end else begin
                        case (bus_wdata[7:5])
                            OP_EOI: begin
                                if (top_hit) st_d.isr[top_line] = 1'b0;
                            end
                            OP_ROT_EOI: begin
                                if (top_hit) begin
                                    st_d.isr[top_line] = 1'b0;
                                    st_d.base          = next_idx(top_line);
                                end
                            end
                            OP_SPEC_EOI: st_d.isr[fld_line] = 1'b0;
                            OP_SET_PRI:  st_d.base = next_idx(fld_line);
                            OP_ROT_SPEC: begin
                                st_d.isr[fld_line] = 1'b0;
                                st_d.base          = next_idx(fld_line);
                            end
                            default: ;
                        endcase
                    end
                end
                ADDR_DATA: begin
                    case (st_q.init)
                        INIT_IDLE: st_d.imr = bus_wdata[LINES-1:0];
                        INIT_BASE: begin
                            st_d.vbase = bus_wdata & VEC_MASK;
                            if (st_q.single)
                                st_d.init = st_q.need4 ? INIT_MODE : INIT_IDLE;
                            else
                                st_d.init = INIT_CASC;
                        end
                        INIT_CASC: st_d.init = st_q.need4 ? INIT_MODE : INIT_IDLE;
                        INIT_MODE: begin
                            st_d.aeoi = bus_wdata[1];
                            st_d.sfnm = bus_wdata[4];
                            st_d.init = INIT_IDLE;
                        end
                        default: st_d.init = INIT_IDLE;
                    endcase
                end
                ADDR_TRIG: st_d.trig = bus_wdata[LINES-1:0] & TRIG_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- assertions ----------------
    AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((st_q.irr & ~st_q.imr) != '0)); // R2

    AST_TRIG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.trig & ~TRIG_MASK) == '0)); // R4

    AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_req && !st_q.aeoi && !bus_wr && !bus_rd) |=> st_q.isr[$past(win_line)]); // R5

    AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CMD && bus_wdata[4]) |=> !int_req); // R6

    AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.aeoi && !bus_wr && !bus_rd) |=> $stable(st_q.isr)); // R8

    AST_SETPRI_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CMD && bus_wdata[4:3] == 2'b00 && bus_wdata[7:5] == OP_SET_PRI)
        |=> st_q.base == next_idx($past(fld_line))); // R10

    AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && win_hit && !ack && !bus_wr) |=> !st_q.isr[$past(win_line)]); // R11

endmodule

// File: tb/pic_core_bench.sv
`timescale 1ns/1ps
module pic_core_bench;
    localparam int LINES = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] irq_in = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic             ack = 1'b0;
    logic [7:0]       ack_vector;
    logic             int_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    pic_core #(.LINES(LINES)) u_pic_core (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack(ack), .ack_vector(ack_vector), .int_req(int_req)
    );

    // monitor: pops one expected byte per read or acknowledge cycle
    always @(negedge clk) begin
        if (rst_n && (bus_rd || ack)) begin
            logic [7:0] got;
            got = bus_rd ? bus_rdata : ack_vector;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard-empty actual=%02h expected=none", got);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got !== e) begin
                    failures++;
                    $display("FAIL %s actual=%02h expected=%02h", t, got, e);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        ack = 1'b1;
        cyc();
        ack = 1'b0;
    endtask

    task automatic chk_int(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (int_req !== e) begin
            failures++;
            $display("FAIL %s int_req actual=%0b expected=%0b", t, int_req, e);
        end
        @(posedge clk); #1;
    endtask

    task automatic pulse(input logic [LINES-1:0] m);
        irq_in = irq_in | m;
        cyc();
        irq_in = irq_in & ~m;
        cyc();
    endtask

    task automatic init(input logic [7:0] vb, input logic [7:0] mode);
        wr(2'd0, 8'h13);
        wr(2'd1, vb);
        wr(2'd1, mode);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();

        // R1 reset state
        chk_int(1'b0, "R1");
        rd(2'd1, 8'h00, "R1 mask");
        rd(2'd0, 8'h00, "R1 request");
        rd(2'd2, 8'h00, "R1 trigger");

        // R7 vector base, R4 edge latch, R5 acknowledge
        init(8'h25, 8'h00);
        pulse(8'h20);
        chk_int(1'b1, "R4 edge held");
        rd(2'd0, 8'h20, "R4 request bit");
        do_ack(8'h25, "R5 R7 vector");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h20, "R5 in-service set");
        wr(2'd0, 8'h0A);
        rd(2'd0, 8'h00, "R5 request cleared");

        // R2 nesting, R9 end-of-interrupt
        pulse(8'h40);
        chk_int(1'b0, "R2 less urgent blocked");
        pulse(8'h08);
        chk_int(1'b1, "R2 more urgent passes");
        do_ack(8'h23, "R2 line3");
        wr(2'd0, 8'h20);
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h20, "R9 nonspecific EOI");
        chk_int(1'b0, "R9 line5 still in service");
        wr(2'd0, 8'h65);
        chk_int(1'b1, "R9 specific EOI");
        do_ack(8'h26, "R9 line6");
        wr(2'd0, 8'h66);
        rd(2'd0, 8'h00, "R9 all retired");

        // R3 mask
        wr(2'd1, 8'h01);
        rd(2'd1, 8'h01, "R3 mask readback");
        pulse(8'h01);
        chk_int(1'b0, "R3 masked");
        wr(2'd1, 8'h00);
        chk_int(1'b1, "R3 unmasked");
        do_ack(8'h20, "R3 line0");
        wr(2'd0, 8'h60);

        // R10 rotation
        wr(2'd0, 8'hC4);
        pulse(8'h50);
        do_ack(8'h26, "R10 set priority base5");
        wr(2'd0, 8'hA0);
        chk_int(1'b1, "R10 pending line4");
        do_ack(8'h24, "R10 rotate EOI base7");
        wr(2'd0, 8'hE4);
        pulse(8'h28);
        do_ack(8'h25, "R10 specific rotate base5");
        wr(2'd0, 8'h65);
        do_ack(8'h23, "R10 line3 next");
        wr(2'd0, 8'h63);
        wr(2'd0, 8'hC7);

        // R4 level sensing and fixed trigger bits
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'hF8, "R4 trigger mask");
        wr(2'd0, 8'h0A);
        irq_in[4] = 1'b1;
        cyc();
        chk_int(1'b1, "R4 level high");
        rd(2'd0, 8'h10, "R4 level request");
        irq_in[4] = 1'b0;
        cyc();
        rd(2'd0, 8'h00, "R4 level follows");
        chk_int(1'b0, "R4 level low");
        wr(2'd2, 8'h00);

        // R11 poll
        pulse(8'h02);
        wr(2'd0, 8'h0C);
        rd(2'd0, 8'h01, "R11 poll line1");
        chk_int(1'b0, "R11 poll cleared");
        wr(2'd0, 8'h0C);
        rd(2'd0, 8'h07, "R11 poll empty");

        // R6 initialization, R8 auto end-of-interrupt
        pulse(8'h20);
        chk_int(1'b1, "R6 pending before start");
        wr(2'd0, 8'h13);
        chk_int(1'b0, "R6 start word");
        wr(2'd1, 8'h48);
        chk_int(1'b0, "R6 awaiting mode");
        wr(2'd1, 8'h02);
        rd(2'd0, 8'h00, "R6 cleared");
        pulse(8'h20);
        do_ack(8'h4D, "R8 auto EOI ack");
        wr(2'd0, 8'h0B);
        rd(2'd0, 8'h00, "R8 no in-service");

        // R12 special nested mode
        init(8'h60, 8'h10);
        pulse(8'h04);
        do_ack(8'h62, "R12 cascade ack");
        pulse(8'h04);
        chk_int(1'b1, "R12 cascade reenters");
        do_ack(8'h62, "R12 second ack");
        wr(2'd0, 8'h62);
        init(8'h60, 8'h00);
        pulse(8'h04);
        do_ack(8'h62, "R12 plain ack");
        pulse(8'h04);
        chk_int(1'b0, "R12 plain blocked");
        do_ack(8'h67, "R5 no winner");

        cyc();
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R5 scoreboard actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule